// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a small processor subsystem from full run into one of four reduced-power states and brings it back. Software selects a target state with a 3-bit code and fires a one-cycle entry strobe; the sequencer then gates the core clock and, for the deeper states, removes power from the PLL, the flash and finally the switchable power domain. The block runs on an always-on reference clock, so its wake logic keeps working in every state. Register and RAM contents are held in all states, so waking never needs a reset.

Each state accepts only its own set of wake sources: timer interrupt, watchdog, RTC alarm and the external interrupt pin. On a legal wake the sequencer restores power in a fixed order: the domain switch first (when it was open), then flash power together with a flash wake-up timer and PLL power. The core clock is released only once the timer has expired and the PLL reports lock. Entry into any state below plain sleep is refused while a debug session is active. The block keeps the last state entered and the set of sources that caused the most recent wake.

Top module: `lpm_seq`

## Requirements
- R1: While reset is held and after its release, every enable output is 1, `last_mode_o` is 0 and `wake_src_o` is 0.
- R2: Entry happens only from run, only on a cycle with `enter_i` high, and only for codes 1 (sleep), 2 (deep sleep), 3 (power-down) and 4 (deep power-down). Codes 0, 5, 6 and 7, and strobes seen while not in run, change nothing. On entry `last_mode_o` takes the code.
- R3: With `dbg_active_i` high, strobes for codes 2, 3 and 4 are refused and the block stays in run; code 1 is still accepted.
- R4: One cycle after an accepted strobe the enables are: sleep, only the core clock off; deep sleep, core clock and PLL off; power-down, core clock, PLL and flash off; deep power-down, all four off.
- R5: Legal wake sources are timer, RTC and external in sleep; watchdog, RTC and external in deep sleep; RTC and external in power-down and deep power-down. Any other source leaves the outputs unchanged.
- R6: A legal wake from sleep turns the core clock on in the very next cycle.
- R7: A wake from deep power-down first closes the domain switch for exactly one cycle with flash and PLL still off; flash and PLL power then come on together.
- R8: When flash power is restored on wake, the core clock turns on no earlier than `FLASH_WAKE_CYC` cycles after flash power rises, and exactly then if PLL lock is already present.
- R9: During restart from deep sleep or a lower state the PLL is powered and the core clock stays off while `pll_lock_i` is low; it turns on the cycle after lock is seen with the flash timer expired.
- R10: On a wake, `wake_src_o` captures the legal sources present (bit 0 timer, bit 1 watchdog, bit 2 RTC, bit 3 external) and holds them until the next wake; wake inputs during run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_req_i | input | 3 | Requested low-power state code |
| enter_i | input | 1 | One-cycle entry strobe |
| dbg_active_i | input | 1 | Debug session active |
| wake_tmr_i | input | 1 | Timer interrupt wake request |
| wake_wdt_i | input | 1 | Watchdog wake request |
| wake_rtc_i | input | 1 | RTC alarm wake request |
| wake_ext_i | input | 1 | External interrupt pin wake request |
| pll_lock_i | input | 1 | PLL lock indication |
| core_clk_en_o | output | 1 | Core clock gate enable |
| flash_pwr_en_o | output | 1 | Flash power enable |
| pll_pwr_en_o | output | 1 | PLL power enable |
| dom_pwr_en_o | output | 1 | Switchable domain power enable |
| last_mode_o | output | 3 | Code of the last state entered |
| wake_src_o | output | 4 | Sources that caused the last wake |

## Verification
Every state is entered and then offered first an illegal wake source and then a legal one, which separates the per-state wake masks from each other and shows that a refused source leaves every enable untouched. Two sources at once in sleep distinguish a captured mask from a single priority pick. Deep sleep is woken with lock held low for several cycles, which tells the lock wait apart from the flash timer, while power-down and deep power-down are woken with lock present so the measured delay to the core clock isolates the timer length and the extra domain cycle. Strobes with a debug session, with unused codes and while asleep check that refused requests alter neither outputs nor the recorded state.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;

    localparam int unsigned NUM_WAKE = 4;
    localparam int unsigned W_TMR = 0;
    localparam int unsigned W_WDT = 1;
    localparam int unsigned W_RTC = 2;
    localparam int unsigned W_EXT = 3;

    typedef enum logic [2:0] {
        MODE_RUN    = 3'd0,
        MODE_SLEEP  = 3'd1,
        MODE_DSLEEP = 3'd2,
        MODE_PDOWN  = 3'd3,
        MODE_DPDOWN = 3'd4
    } lpm_mode_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_LOWP    = 2'd1,
        ST_DOMUP   = 2'd2,
        ST_RESTART = 2'd3
    } lpm_state_e;

    typedef struct packed {
        lpm_state_e            st;
        lpm_mode_e             mode;
        logic [2:0]            last;
        logic [NUM_WAKE-1:0]   src;
    } lpm_regs_t;

    function automatic logic [NUM_WAKE-1:0] wake_mask(lpm_mode_e m);
        logic [NUM_WAKE-1:0] msk;
        msk = '0;
        case (m)
            MODE_SLEEP: begin
                msk[W_TMR] = 1'b1;
                msk[W_RTC] = 1'b1;
                msk[W_EXT] = 1'b1;
            end
            MODE_DSLEEP: begin
                msk[W_WDT] = 1'b1;
                msk[W_RTC] = 1'b1;
                msk[W_EXT] = 1'b1;
            end
            MODE_PDOWN, MODE_DPDOWN: begin
                msk[W_RTC] = 1'b1;
                msk[W_EXT] = 1'b1;
            end
            default: msk = '0;
        endcase
        return msk;
    endfunction

endpackage

// File: rtl/lpm_wake_filter.sv
`timescale 1ns/1ps
module lpm_wake_filter
    import lpm_pkg::*;
(
    input  lpm_mode_e              mode_i,
    input  logic [NUM_WAKE-1:0]    raw_i,
    output logic [NUM_WAKE-1:0]    legal_o,
    output logic                   any_o
);
    always_comb begin
        legal_o = raw_i & wake_mask(mode_i);
        any_o   = |legal_o;
    end
endmodule

// File: rtl/lpm_flash_timer.sv
`timescale 1ns/1ps
module lpm_flash_timer #(
    parameter int unsigned CYC = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic arm_i,
    output logic done_o
);
    localparam int unsigned CW = (CYC < 2) ? 1 : $clog2(CYC);
    localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = arm_i ? LOAD : '0;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lpm_power_decode.sv
`timescale 1ns/1ps
module lpm_power_decode
    import lpm_pkg::*;
(
    input  lpm_state_e st_i,
    input  lpm_mode_e  mode_i,
    output logic       core_o,
    output logic       flash_o,
    output logic       pll_o,
    output logic       dom_o
);
    always_comb begin
        core_o  = 1'b0;
        flash_o = 1'b1;
        pll_o   = 1'b1;
        dom_o   = 1'b1;
        case (st_i)
            ST_RUN: core_o = 1'b1;
            ST_LOWP: begin
                case (mode_i)
                    MODE_SLEEP: ;
                    MODE_DSLEEP: pll_o = 1'b0;
                    MODE_PDOWN: begin
                        pll_o   = 1'b0;
                        flash_o = 1'b0;
                    end
                    default: begin
                        pll_o   = 1'b0;
                        flash_o = 1'b0;
                        dom_o   = 1'b0;
                    end
                endcase
            end
            ST_DOMUP: begin
                pll_o   = 1'b0;
                flash_o = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lpm_seq.sv
`timescale 1ns/1ps
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int unsigned FLASH_WAKE_CYC = 100
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] mode_req_i,
    input  logic       enter_i,
    input  logic       dbg_active_i,
    input  logic       wake_tmr_i,
    input  logic       wake_wdt_i,
    input  logic       wake_rtc_i,
    input  logic       wake_ext_i,
    input  logic       pll_lock_i,
    output logic       core_clk_en_o,
    output logic       flash_pwr_en_o,
    output logic       pll_pwr_en_o,
    output logic       dom_pwr_en_o,
    output logic [2:0] last_mode_o,
    output logic [3:0] wake_src_o
);
    lpm_regs_t r_d, r_q;

    logic [NUM_WAKE-1:0] raw_wake;
    logic [NUM_WAKE-1:0] legal_wake;
    logic                wake_any;
    logic                tmr_start, tmr_arm, tmr_done;
    logic                req_ok, req_deep;

    always_comb begin
        raw_wake        = '0;
        raw_wake[W_TMR] = wake_tmr_i;
        raw_wake[W_WDT] = wake_wdt_i;
        raw_wake[W_RTC] = wake_rtc_i;
        raw_wake[W_EXT] = wake_ext_i;
    end

    lpm_wake_filter u_filt (
        .mode_i  (r_q.mode),
        .raw_i   (raw_wake),
        .legal_o (legal_wake),
        .any_o   (wake_any)
    );

    lpm_flash_timer #(.CYC(FLASH_WAKE_CYC)) u_ftmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (tmr_start),
        .arm_i   (tmr_arm),
        .done_o  (tmr_done)
    );

    lpm_power_decode u_dec (
        .st_i    (r_q.st),
        .mode_i  (r_q.mode),
        .core_o  (core_clk_en_o),
        .flash_o (flash_pwr_en_o),
        .pll_o   (pll_pwr_en_o),
        .dom_o   (dom_pwr_en_o)
    );

    always_comb begin
        req_ok   = (mode_req_i >= 3'd1) && (mode_req_i <= 3'd4);
        req_deep = (mode_req_i >= 3'd2);
        r_d       = r_q;
        tmr_start = 1'b0;
        tmr_arm   = 1'b0;
        case (r_q.st)
            ST_RUN: begin
                if (enter_i && req_ok && !(dbg_active_i && req_deep)) begin
                    r_d.st   = ST_LOWP;
                    r_d.mode = lpm_mode_e'(mode_req_i);
                    r_d.last = mode_req_i;
                end
            end
            ST_LOWP: begin
                if (wake_any) begin
                    r_d.src = legal_wake;
                    case (r_q.mode)
                        MODE_SLEEP: begin
                            r_d.st   = ST_RUN;
                            r_d.mode = MODE_RUN;
                        end
                        MODE_DPDOWN: r_d.st = ST_DOMUP;
                        default: begin
                            r_d.st    = ST_RESTART;
                            tmr_start = 1'b1;
                            tmr_arm   = (r_q.mode == MODE_PDOWN);
                        end
                    endcase
                end
            end
            ST_DOMUP: begin
                r_d.st    = ST_RESTART;
                tmr_start = 1'b1;
                tmr_arm   = 1'b1;
            end
            default: begin
                if (tmr_done && pll_lock_i) begin
                    r_d.st   = ST_RUN;
                    r_d.mode = MODE_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_RUN, mode: MODE_RUN, last: 3'd0, src: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign last_mode_o = r_q.last;
    assign wake_src_o  = r_q.src;
endmodule

// File: rtl/lpm_seq_chk.sv
`timescale 1ns/1ps
module lpm_seq_chk #(
    parameter int unsigned FLASH_WAKE_CYC = 100
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [2:0] mode_req_i,
    input logic       enter_i,
    input logic       dbg_active_i,
    input logic       core_clk_en_o,
    input logic       flash_pwr_en_o,
    input logic       pll_pwr_en_o,
    input logic       dom_pwr_en_o,
    input logic [2:0] last_mode_o,
    input logic [3:0] wake_src_o
);
    logic        fl_prev_q, armed_q;
    int unsigned since_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fl_prev_q <= 1'b1;
            armed_q   <= 1'b0;
            since_q   <= 0;
        end else begin
            fl_prev_q <= flash_pwr_en_o;
            if (flash_pwr_en_o && !fl_prev_q) begin
                since_q <= 1;
                armed_q <= 1'b1;
            end else begin
                if (since_q != 32'hFFFF_FFFF) since_q <= since_q + 1;
                if (core_clk_en_o) armed_q <= 1'b0;
            end
        end
    end

    a_r4_pll_gates_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pll_pwr_en_o |-> !core_clk_en_o);

    a_r4_flash_off_pll_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flash_pwr_en_o |-> !pll_pwr_en_o);

    a_r7_domain_before_flash: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flash_pwr_en_o) |-> dom_pwr_en_o && $past(dom_pwr_en_o));

    a_r8_flash_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(core_clk_en_o) && armed_q |-> since_q >= FLASH_WAKE_CYC);

    a_r9_pll_on_before_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(core_clk_en_o) |-> $past(pll_pwr_en_o));

    a_r3_debug_blocks_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_clk_en_o && enter_i && dbg_active_i && (mode_req_i >= 3'd2) |=> core_clk_en_o);

    a_r2_last_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_mode_o <= 3'd4);

    a_r10_src_held_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_clk_en_o |=> $stable(wake_src_o));
endmodule

bind lpm_seq lpm_seq_chk #(.FLASH_WAKE_CYC(FLASH_WAKE_CYC)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_req_i     (mode_req_i),
    .enter_i        (enter_i),
    .dbg_active_i   (dbg_active_i),
    .core_clk_en_o  (core_clk_en_o),
    .flash_pwr_en_o (flash_pwr_en_o),
    .pll_pwr_en_o   (pll_pwr_en_o),
    .dom_pwr_en_o   (dom_pwr_en_o),
    .last_mode_o    (last_mode_o),
    .wake_src_o     (wake_src_o)
);

// File: tb/tb_lpm_seq.sv
`timescale 1ns/1ps
module tb_lpm_seq;
    localparam int unsigned NCYC = 100;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [2:0] mode_req_i = 3'd0;
    logic       enter_i = 1'b0;
    logic       dbg_active_i = 1'b0;
    logic       wake_tmr_i = 1'b0;
    logic       wake_wdt_i = 1'b0;
    logic       wake_rtc_i = 1'b0;
    logic       wake_ext_i = 1'b0;
    logic       pll_lock_i = 1'b1;
    logic       core_clk_en_o, flash_pwr_en_o, pll_pwr_en_o, dom_pwr_en_o;
    logic [2:0] last_mode_o;
    logic [3:0] wake_src_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2.5 clk_i = ~clk_i;

    lpm_seq #(.FLASH_WAKE_CYC(NCYC)) dut (
        .clk_i, .rst_ni, .mode_req_i, .enter_i, .dbg_active_i,
        .wake_tmr_i, .wake_wdt_i, .wake_rtc_i, .wake_ext_i, .pll_lock_i,
        .core_clk_en_o, .flash_pwr_en_o, .pll_pwr_en_o, .dom_pwr_en_o,
        .last_mode_o, .wake_src_o
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk_i);
    endtask

    // enables packed as {core, flash, pll, dom}
    function automatic int en();
        return {core_clk_en_o, flash_pwr_en_o, pll_pwr_en_o, dom_pwr_en_o};
    endfunction

    task automatic strobe(input logic [2:0] m);
        mode_req_i = m;
        enter_i = 1'b1;
        tick();
        enter_i = 1'b0;
    endtask

    // wake vector: bit0 timer, bit1 watchdog, bit2 RTC, bit3 external
    task automatic pulse(input logic [3:0] w);
        {wake_ext_i, wake_rtc_i, wake_wdt_i, wake_tmr_i} = w;
        tick();
        {wake_ext_i, wake_rtc_i, wake_wdt_i, wake_tmr_i} = 4'b0;
    endtask

    task automatic count_to_core(input string tag);
        int n = 0;
        while (!core_clk_en_o && n < 1000) begin
            tick();
            n++;
        end
        check(tag, n, NCYC);
    endtask

    task automatic t_reset();
        rst_ni = 1'b0;
        repeat (3) tick();
        check("R1 enables in reset", en(), 4'b1111);
        rst_ni = 1'b1;
        tick();
        check("R1 enables after reset", en(), 4'b1111);
        check("R1 last mode", last_mode_o, 0);
        check("R1 wake source", wake_src_o, 0);
    endtask

    task automatic t_sleep();
        strobe(3'd1);
        check("R4 sleep enables", en(), 4'b0111);
        check("R2 last mode sleep", last_mode_o, 1);
        pulse(4'b0010);
        repeat (3) tick();
        check("R5 watchdog ignored in sleep", en(), 4'b0111);
        pulse(4'b0001);
        check("R6 core on after timer wake", en(), 4'b1111);
        check("R10 source timer", wake_src_o, 1);
        pulse(4'b1111);
        check("R10 wake in run ignored", wake_src_o, 1);
        check("R10 run unaffected", en(), 4'b1111);
        strobe(3'd1);
        pulse(4'b1001);
        check("R10 two sources captured", wake_src_o, 9);
        check("R6 core on after dual wake", core_clk_en_o, 1);
    endtask

    task automatic t_strobe_while_asleep();
        strobe(3'd1);
        strobe(3'd3);
        check("R2 strobe ignored asleep", en(), 4'b0111);
        check("R2 last mode kept", last_mode_o, 1);
        pulse(4'b0100);
        check("R5 rtc wakes sleep", core_clk_en_o, 1);
        check("R10 source rtc", wake_src_o, 4);
    endtask

    task automatic t_debug();
        dbg_active_i = 1'b1;
        for (int m = 2; m <= 4; m++) begin
            strobe(3'(m));
            check("R3 deep entry refused", en(), 4'b1111);
            check("R3 last mode kept", last_mode_o, 1);
        end
        strobe(3'd1);
        check("R3 sleep allowed in debug", en(), 4'b0111);
        pulse(4'b1000);
        check("R5 ext wakes sleep", core_clk_en_o, 1);
        dbg_active_i = 1'b0;
    endtask

    task automatic t_deep_sleep();
        strobe(3'd2);
        check("R4 deep sleep enables", en(), 4'b0101);
        check("R2 last mode deep sleep", last_mode_o, 2);
        pll_lock_i = 1'b0;
        pulse(4'b0001);
        check("R5 timer ignored in deep sleep", en(), 4'b0101);
        pulse(4'b0010);
        check("R9 restart powers pll", en(), 4'b0111);
        repeat (5) tick();
        check("R9 core held without lock", core_clk_en_o, 0);
        pll_lock_i = 1'b1;
        tick();
        check("R9 core on after lock", core_clk_en_o, 1);
        check("R10 source watchdog", wake_src_o, 2);
    endtask

    task automatic t_power_down();
        strobe(3'd3);
        check("R4 power-down enables", en(), 4'b0001);
        pll_lock_i = 1'b0;
        pulse(4'b0010);
        check("R5 watchdog ignored in power-down", en(), 4'b0001);
        pulse(4'b1000);
        check("R8 flash and pll on at wake", en(), 4'b0111);
        pll_lock_i = 1'b1;
        count_to_core("R8 flash delay power-down");
        check("R10 source ext", wake_src_o, 8);
    endtask

    task automatic t_deep_power_down();
        strobe(3'd4);
        check("R4 deep power-down enables", en(), 4'b0000);
        check("R2 last mode deep power-down", last_mode_o, 4);
        pll_lock_i = 1'b0;
        pulse(4'b0011);
        check("R5 timer and watchdog ignored", en(), 4'b0000);
        pulse(4'b0100);
        check("R7 domain first", en(), 4'b0001);
        tick();
        check("R7 flash and pll second", en(), 4'b0111);
        pll_lock_i = 1'b1;
        count_to_core("R8 flash delay deep power-down");
        check("R10 source rtc after deep power-down", wake_src_o, 4);
    endtask

    task automatic t_bad_codes();
        strobe(3'd0);
        strobe(3'd5);
        strobe(3'd6);
        strobe(3'd7);
        check("R2 unused codes ignored", en(), 4'b1111);
        check("R2 last mode unchanged", last_mode_o, 4);
    endtask

    initial begin
        tick();
        t_reset();
        t_sleep();
        t_strobe_while_asleep();
        t_debug();
        t_deep_sleep();
        t_power_down();
        t_deep_power_down();
        t_bad_codes();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule